// File: doc/BRIEF.md
# Address Latch with Step Unit

This block keeps the current memory address of a small 8-bit-era processor core and works out the address that comes next. A 16-bit register takes its value from a shared, bidirectional internal address bus. A combinational step unit sits behind it and produces one of the following from the held value: the value plus one, the value minus one, the value unchanged, or zero. A narrow mode steps only the low six bits, which suits a refresh counter that wraps inside its own field.

The address pins are fed through a two-level selector. By default the held value goes to the pins. One select bit routes the step result to the pins instead. A second select bit takes priority over the first and puts the bus value on the pins. The block can also drive the step result back onto the shared bus, through tri-state drivers, so that the sequencer can write it into a register. A status bit is high when the pin address is exactly one.

The instruction sequencer that sets the control inputs, the register file on the other side of the bus, and the timing of the external pins are not part of this block.

Top module: `addr_step_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, the held address is 0x0000 and both select registers pick the held-address path, so `addr_o` reads 0x0000 and `addr_is_one_o` reads 0.
- R2: On a rising clock edge with `latch_we_i` high, the held address takes the value on `abus`. With `latch_we_i` low it keeps its value.
- R3: The step result is the held address plus 1 when `step_en_i`=1 and `step_dec_i`=0. It is the held address minus 1 when `step_en_i`=1 and `step_dec_i`=1. It equals the held address, for either value of `step_dec_i`, when `step_en_i`=0.
- R4: Stepping wraps modulo 2^16: 0xFFFF+1 gives 0x0000, 0x0000-1 gives 0xFFFF, and 0xFFFF-1 gives 0xFFFE.
- R5: With `step_narrow_i`=1, result bits 15:6 equal the held bits 15:6. Bits 5:0 step on their own, wrapping from 0x3F to 0x00 going up and from 0x00 to 0x3F going down.
- R6: With `step_clear_i`=1 the step result is 0x0000. This holds whatever the values of direction, step enable and narrow mode.
- R7: `sel_step_i` and `sel_bus_i` are captured on each rising edge and take effect from that edge on. With the captured bus select at 1, `addr_o` shows `abus`. Otherwise, with the captured step select at 1, `addr_o` shows the step result. Otherwise `addr_o` shows the held address.
- R8: With `bus_oe_i`=1 the block drives the step result onto `abus`. With `bus_oe_i`=0 it leaves `abus` undriven, so a value driven by another agent is read unchanged, both at `addr_o` and by a latch load.
- R9: `addr_is_one_o` is 1 exactly when `addr_o` equals 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| abus | inout | 16 | Shared internal address bus |
| latch_we_i | input | 1 | Load held address from the bus |
| step_en_i | input | 1 | Step size one (1) or zero (0) |
| step_dec_i | input | 1 | Step downward (1) or upward (0) |
| step_narrow_i | input | 1 | Restrict stepping to the low six bits |
| step_clear_i | input | 1 | Force the step result to zero |
| sel_step_i | input | 1 | Route step result to the pins (captured) |
| sel_bus_i | input | 1 | Route bus to the pins, overrides step select (captured) |
| bus_oe_i | input | 1 | Drive step result onto the bus |
| addr_o | output | 16 | Address pin value |
| addr_is_one_o | output | 1 | High when `addr_o` is 0x0001 |

## Verification
The hardest cases to reach are the narrow-mode wrap and the full-width wrap, because both need a held value that sits exactly at a boundary. Random bus data almost never lands there. The stimulus therefore loads 0xFFFF, 0x0000, and values whose low six bits are 0x3F or 0x00 before it steps them. The random phase also draws bus words from a small set of boundary patterns for a share of the loads. A second awkward case is a cycle that loads the latch while the block is itself driving the bus, so that the held value becomes its own step result. The random phase turns on `bus_oe_i` and `latch_we_i` together often enough to cover this, and in those cycles the bench releases its bus driver.

// File: rtl/addr_step_pkg.sv
package addr_step_pkg;

   // Control bundle for the step unit
   typedef struct packed {
      logic en;      // step size one when set
      logic dec;     // downward when set
      logic narrow;  // low-field stepping only
      logic clear;   // force zero, highest priority
   } step_op_t;

   // Source currently presented on the pins
   typedef enum logic [1:0] {
      SRC_HELD = 2'd0,
      SRC_STEP = 2'd1,
      SRC_BUS  = 2'd2
   } addr_src_e;

endpackage

// File: rtl/addr_latch_reg.sv
module addr_latch_reg #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [WIDTH-1:0] data_i,
   output logic [WIDTH-1:0] held_o
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("addr_latch_reg: WIDTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_o <= '0;
      end else if (load_i) begin
         held_o <= data_i;
      end
   end

endmodule

// File: rtl/addr_stepper.sv
module addr_stepper
   import addr_step_pkg::*;
#(
   parameter int unsigned WIDTH    = 16,
   parameter int unsigned NARROW_W = 6
) (
   input  logic [WIDTH-1:0] base_i,
   input  step_op_t         op_i,
   output logic [WIDTH-1:0] result_o
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   logic [WIDTH-1:0] step_val;
   logic [WIDTH-1:0] wide_sum;
   logic [WIDTH-1:0] stepped;

   // Step value: +1, -1 (all ones) or 0
   always_comb begin
      if (!op_i.en)
         step_val = '0;
      else if (op_i.dec)
         step_val = '1;
      else
         step_val = ONE;
   end

   assign wide_sum = base_i + step_val;

   generate
      if (NARROW_W >= WIDTH) begin : g_bad_narrow
         $error("addr_stepper: NARROW_W must be below WIDTH");
      end

      if (NARROW_W > 0 && NARROW_W < WIDTH) begin : g_narrow
         logic [NARROW_W-1:0] low_sum;
         // Carry out of the low field is dropped on purpose
         assign low_sum = base_i[NARROW_W-1:0] + step_val[NARROW_W-1:0];
         always_comb begin
            if (op_i.narrow)
               stepped = {base_i[WIDTH-1:NARROW_W], low_sum};
            else
               stepped = wide_sum;
         end
      end else begin : g_wide_only
         logic unused_narrow;
         assign unused_narrow = op_i.narrow;
         assign stepped = wide_sum;
      end
   endgenerate

   // Clear overrides every other control
   assign result_o = op_i.clear ? '0 : stepped;

endmodule

// File: rtl/addr_out_sel.sv
module addr_out_sel
   import addr_step_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_step_i,
   input  logic             sel_bus_i,
   input  logic [WIDTH-1:0] held_i,
   input  logic [WIDTH-1:0] step_i,
   input  logic [WIDTH-1:0] bus_i,
   output logic [WIDTH-1:0] addr_o,
   output logic             is_one_o
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   addr_src_e src_q;
   addr_src_e src_d;

   // Bus select outranks step select
   always_comb begin
      if (sel_bus_i)
         src_d = SRC_BUS;
      else if (sel_step_i)
         src_d = SRC_STEP;
      else
         src_d = SRC_HELD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         src_q <= SRC_HELD;
      else
         src_q <= src_d;
   end

   always_comb begin
      case (src_q)
         SRC_STEP: addr_o = step_i;
         SRC_BUS:  addr_o = bus_i;
         default:  addr_o = held_i;
      endcase
   end

   assign is_one_o = (addr_o == ONE);

endmodule

// File: rtl/addr_step_unit.sv
module addr_step_unit
   import addr_step_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned NARROW_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   inout  wire  [ADDR_W-1:0] abus,
   input  logic              latch_we_i,
   input  logic              step_en_i,
   input  logic              step_dec_i,
   input  logic              step_narrow_i,
   input  logic              step_clear_i,
   input  logic              sel_step_i,
   input  logic              sel_bus_i,
   input  logic              bus_oe_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              addr_is_one_o
);

   logic [ADDR_W-1:0] held_q;
   logic [ADDR_W-1:0] step_res;
   step_op_t          op;

   assign op = '{en: step_en_i, dec: step_dec_i,
                 narrow: step_narrow_i, clear: step_clear_i};

   addr_latch_reg #(.WIDTH(ADDR_W)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (latch_we_i),
      .data_i (abus),
      .held_o (held_q)
   );

   addr_stepper #(.WIDTH(ADDR_W), .NARROW_W(NARROW_W)) u_step (
      .base_i   (held_q),
      .op_i     (op),
      .result_o (step_res)
   );

   addr_out_sel #(.WIDTH(ADDR_W)) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_step_i (sel_step_i),
      .sel_bus_i  (sel_bus_i),
      .held_i     (held_q),
      .step_i     (step_res),
      .bus_i      (abus),
      .addr_o     (addr_o),
      .is_one_o   (addr_is_one_o)
   );

   // Tri-state driver onto the shared bus
   assign abus = bus_oe_i ? step_res : {ADDR_W{1'bz}};

endmodule

// File: rtl/addr_step_chk.sv
module addr_step_chk #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned NARROW_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] abus,
   input logic              latch_we_i,
   input logic              step_en_i,
   input logic              step_dec_i,
   input logic              step_narrow_i,
   input logic              step_clear_i,
   input logic [ADDR_W-1:0] held_q,
   input logic [ADDR_W-1:0] step_res
);

   localparam logic [ADDR_W-1:0] ALL1 = '1;

   a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      latch_we_i |=> held_q == $past(abus));

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_we_i |=> $stable(held_q));

   a_r3_zero_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_en_i && !step_clear_i) |-> step_res == held_q);

   a_r4_top_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en_i && !step_dec_i && !step_narrow_i && !step_clear_i
       && held_q == ALL1) |-> step_res == '0);

   a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (step_narrow_i && !step_clear_i)
      |-> step_res[ADDR_W-1:NARROW_W] == held_q[ADDR_W-1:NARROW_W]);

   a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      step_clear_i |-> step_res == '0);

endmodule

bind addr_step_unit addr_step_chk #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .abus          (abus),
   .latch_we_i    (latch_we_i),
   .step_en_i     (step_en_i),
   .step_dec_i    (step_dec_i),
   .step_narrow_i (step_narrow_i),
   .step_clear_i  (step_clear_i),
   .held_q        (held_q),
   .step_res      (step_res)
);

// File: tb/tb_addr_step_unit.sv
`timescale 1ns/1ps
module tb_addr_step_unit;

   localparam int W  = 16;
   localparam int NW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   wire  [W-1:0] abus;
   logic [W-1:0] drv = '0;
   logic         drv_en = 1'b1;
   assign abus = drv_en ? drv : {W{1'bz}};

   logic we = 0, en = 0, dec = 0, nar = 0, clr = 0, ss = 0, sb = 0, oe = 0;
   logic [W-1:0] addr;
   logic         is_one;

   addr_step_unit dut (
      .clk(clk), .rst_n(rst_n), .abus(abus),
      .latch_we_i(we), .step_en_i(en), .step_dec_i(dec),
      .step_narrow_i(nar), .step_clear_i(clr),
      .sel_step_i(ss), .sel_bus_i(sb), .bus_oe_i(oe),
      .addr_o(addr), .addr_is_one_o(is_one));

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // Model state
   logic [W-1:0] m_held = '0;
   logic         m_ss = 0, m_sb = 0;

   function automatic logic [W-1:0] step_model(input logic [W-1:0] b,
      input logic e, input logic d, input logic n, input logic c);
      logic [W-1:0] s;
      logic [NW-1:0] lo;
      s = e ? (d ? b - 1'b1 : b + 1'b1) : b;
      lo = e ? (d ? b[NW-1:0] - 1'b1 : b[NW-1:0] + 1'b1) : b[NW-1:0];
      if (n) s = {b[W-1:NW], lo};
      if (c) s = '0;
      return s;
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One cycle: drive at negedge, check combinational outputs, update model at posedge
   task automatic cyc(input logic i_we, input logic [W-1:0] i_d, input logic i_en,
      input logic i_dec, input logic i_nar, input logic i_clr,
      input logic i_ss, input logic i_sb, input logic i_oe);
      logic [W-1:0] res, busv, exp;
      string tag;
      we = i_we; en = i_en; dec = i_dec; nar = i_nar; clr = i_clr;
      ss = i_ss; sb = i_sb; oe = i_oe;
      drv = i_d; drv_en = !i_oe;
      #1;
      res  = step_model(m_held, i_en, i_dec, i_nar, i_clr);
      busv = i_oe ? res : i_d;
      if (m_sb) begin
         exp = busv;
         tag = i_oe ? "R8" : "R7";
      end else if (m_ss) begin
         exp = res;
         if (i_clr) tag = "R6";
         else if (i_nar) tag = "R5";
         else if (i_en && ((m_held == '1 && !i_dec) || (m_held == '0 && i_dec))) tag = "R4";
         else tag = "R3";
      end else begin
         exp = m_held;
         tag = "R2";
      end
      check(tag, addr, exp);
      check("R9", {{(W-1){1'b0}}, is_one}, {{(W-1){1'b0}}, exp == 16'h0001});
      @(posedge clk);
      if (i_we) m_held = busv;
      m_ss = i_ss; m_sb = i_sb;
      @(negedge clk);
   endtask

   // Load a value and show the step result next cycle
   task automatic show_step(input logic [W-1:0] v, input logic e, input logic d,
      input logic n, input logic c);
      cyc(1, v, 0, 0, 0, 0, 1, 0, 0);
      cyc(0, 16'h0, e, d, n, c, 1, 0, 0);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      @(negedge clk);
      #1;
      check("R1", addr, 16'h0000);
      check("R1", {15'd0, is_one}, 16'd0);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // First cycle after reset: held path, zero
      cyc(0, 16'hBEEF, 1, 0, 0, 0, 0, 0, 0);   // R1 via model (held=0)

      // R3 basic step
      show_step(16'h1234, 1, 0, 0, 0);
      show_step(16'h1234, 1, 1, 0, 0);
      show_step(16'h1234, 0, 1, 0, 0);
      // R4 wraps
      show_step(16'hFFFF, 1, 0, 0, 0);
      show_step(16'h0000, 1, 1, 0, 0);
      show_step(16'hFFFF, 1, 1, 0, 0);
      // R9 flag at one
      show_step(16'h0000, 1, 0, 0, 0);
      show_step(16'h0002, 1, 1, 0, 0);
      // R5 narrow wraps
      show_step(16'hA53F, 1, 0, 1, 0);
      show_step(16'hA5C0, 1, 1, 1, 0);
      show_step(16'hFFFF, 1, 0, 1, 0);
      // R6 clear priority
      show_step(16'h7777, 1, 1, 1, 1);
      show_step(16'hFFFF, 1, 0, 0, 1);
      // R2 hold with write-enable low
      cyc(1, 16'hAA50, 0, 0, 0, 0, 0, 0, 0);
      cyc(0, 16'h1111, 1, 0, 0, 0, 0, 0, 0);
      cyc(0, 16'h2222, 1, 0, 0, 0, 0, 0, 0);
      // R7 bus select overrides step select
      cyc(0, 16'h3333, 1, 0, 0, 0, 1, 1, 0);
      cyc(0, 16'h0001, 1, 0, 0, 0, 0, 0, 0);
      // R8 drive result onto bus, reload from self
      cyc(0, 16'h0, 1, 0, 0, 0, 0, 1, 1);
      cyc(1, 16'h0, 1, 0, 0, 0, 0, 1, 1);
      cyc(0, 16'h5A5A, 0, 0, 0, 0, 0, 0, 0);

      // Random phase
      for (int i = 0; i < 3000; i++) begin
         logic [W-1:0] d;
         logic [31:0] r;
         r = $urandom;
         case (r[2:0])
            3'd0: d = 16'hFFFF;
            3'd1: d = 16'h0000;
            3'd2: d = {$urandom_range(0, 1023), 6'h3F};
            3'd3: d = {$urandom_range(0, 1023), 6'h00};
            3'd4: d = 16'h0001;
            default: d = $urandom;
         endcase
         cyc(r[3], d, r[4], r[5], r[6] & r[7], r[8] & r[9] & r[10],
             r[11] | r[12], r[13] & r[14], r[15] & r[16]);
      end

      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule